// File: doc/BRIEF.md
# Thermally Assisted Magnetic Cell Operation Sequencer

This block runs one operation on a single addressed cell of a 32 x 32 magnetic memory array in which writing relies on local heating. A write heats the selected cell, applies a field current whose direction selects the stored value, and then turns the heating off while keeping the field current on so the cell cools into the new state. A read applies a low heating bias so that an external converter can sample the cell. The block has no analog outputs. It produces three 8-bit voltage codes, for the heating line and the two field lines, which external DACs or potentiometers turn into voltages. It also produces one strobe per phase so that the analog front end can follow the sequence.

Four operations are supported: a reliable write of 0, a reliable write of 1, an uncertain write of 0, and a read. The uncertain write uses the field settings of the reliable write of 0. Its heating level is taken from a programmable input and is deliberately kept near the switching threshold, so that the cell fails to switch about half of the time. A physically unclonable response is built from a reliable write of 1 followed by an uncertain write of 0 and then a read. Pulse lengths are given in clock cycles. The default is 3 cycles, which is 30 ns at 100 MHz.

Top module: `tas_cell_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o`, `done_o`, `sample_o` and all phase strobes are 0, all three voltage codes are 0, and `addr_o` is 0 until the first operation is accepted.
- R2: When `start_i` is sampled high while the block is idle, the operation begins. From the next cycle `addr_o` shows the address that was captured with the request.
- R3: A write (`op_i` 0, 1 or 2) runs a heat phase, then a field phase, then a cool phase. Each phase lasts PULSE_CYC cycles, and exactly one phase strobe is high while the block is busy. A read (`op_i` 3) runs only a heat phase of PULSE_CYC cycles.
- R4: Write 0 (`op_i`=0) outputs heat code 110 (2.2 V) in the heat and field phases. In the field and cool phases it outputs field-1 code 165 (3.3 V) and field-2 code 0. One code step is 20 mV.
- R5: Write 1 (`op_i`=1) outputs heat code 165 (3.3 V) in the heat and field phases. In the field and cool phases it outputs field-1 code 0 and field-2 code 110 (2.2 V).
- R6: Uncertain write 0 (`op_i`=2) uses the field codes of R4. Its heat code is `uw_heat_i`, captured at start and clamped to the range 50..90 (1.0 V to 1.8 V).
- R7: A read (`op_i`=3) outputs heat code 15 (0.3 V), and both field codes stay 0 for the whole operation.
- R8: `sample_o` is high only in the last heat-phase cycle of a read.
- R9: `done_o` is high for exactly one cycle: the last cycle of the cool phase for a write, or the last cycle of a read. The block is idle in the next cycle.
- R10: A `start_i` sampled while the block is busy is ignored, including in the `done_o` cycle. It does not change the address, the operation or the timing.
- R11: In the cool phase the heat code is 0, and both field codes keep the values they had in the field phase.
- R12: While no phase is active, both field codes and the heat code are driven to 0, and no phase strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to start an operation |
| op_i | input | 2 | Operation: 0 write 0, 1 write 1, 2 uncertain write 0, 3 read |
| addr_i | input | 10 | Cell address (row and column) |
| uw_heat_i | input | 8 | Heating code for the uncertain write |
| addr_o | output | 10 | Address of the current or last operation |
| heat_code_o | output | 8 | Heating-line voltage code |
| fld1_code_o | output | 8 | Field line 1 voltage code |
| fld2_code_o | output | 8 | Field line 2 voltage code |
| heat_en_o | output | 1 | Heat phase active |
| field_en_o | output | 1 | Field phase active |
| cool_en_o | output | 1 | Cool phase active |
| sample_o | output | 1 | Converter sample strobe during a read |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The end of an operation and a new start request can land in the same cycle. Because the block is still busy when `done_o` is high, that request must be dropped and must not start an operation one cycle later. The bench tests this in two ways. It raises `start_i` exactly in the `done_o` cycle, with a different address and operation, and checks that the block goes idle with the old address still on `addr_o`. It also holds `start_i` high across several operations and checks that each new operation begins only after one idle cycle. A read has its own coincidence, where the sample strobe and `done_o` share the last cycle. The cycle-by-cycle reference model checks that case on every read.

// File: rtl/tas_seq_pkg.sv
package tas_seq_pkg;

  typedef enum logic [1:0] {
    OP_CW0  = 2'd0,
    OP_CW1  = 2'd1,
    OP_UW0  = 2'd2,
    OP_READ = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HEAT  = 2'd1,
    PH_FIELD = 2'd2,
    PH_COOL  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [7:0] heat;
    logic [7:0] f1;
    logic [7:0] f2;
  } drive_t;

  // Millivolts to an 8-bit code with a given step size.
  function automatic logic [7:0] mv_code(input int unsigned mv, input int unsigned lsb_mv);
    return 8'(mv / lsb_mv);
  endfunction

  // Keep a code inside [lo, hi].
  function automatic logic [7:0] clamp_code(input logic [7:0] c, input logic [7:0] lo,
                                            input logic [7:0] hi);
    if (c < lo) return lo;
    if (c > hi) return hi;
    return c;
  endfunction

endpackage

// File: rtl/tas_phase_timer.sv
module tas_phase_timer #(
  parameter int PULSE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == CNT_W'(PULSE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || last_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tas_level_map.sv
module tas_level_map
  import tas_seq_pkg::*;
#(
  parameter int LSB_MV    = 20,
  parameter int UW_MIN_MV = 1000,
  parameter int UW_MAX_MV = 1800
) (
  input  op_e        op_i,
  input  phase_e     phase_i,
  input  logic [7:0] uw_heat_i,
  output drive_t     drive_o
);
  localparam logic [7:0] C_3V3  = mv_code(3300, LSB_MV);
  localparam logic [7:0] C_2V2  = mv_code(2200, LSB_MV);
  localparam logic [7:0] C_0V3  = mv_code(300, LSB_MV);
  localparam logic [7:0] C_UWLO = mv_code(UW_MIN_MV, LSB_MV);
  localparam logic [7:0] C_UWHI = mv_code(UW_MAX_MV, LSB_MV);

  logic [7:0] heat_lvl, f1_lvl, f2_lvl;

  always_comb begin
    heat_lvl = '0;
    f1_lvl   = '0;
    f2_lvl   = '0;
    unique case (op_i)
      OP_CW0: begin heat_lvl = C_2V2; f1_lvl = C_3V3; end
      OP_CW1: begin heat_lvl = C_3V3; f2_lvl = C_2V2; end
      OP_UW0: begin heat_lvl = clamp_code(uw_heat_i, C_UWLO, C_UWHI); f1_lvl = C_3V3; end
      OP_READ: heat_lvl = C_0V3;
      default: ;
    endcase
  end

  always_comb begin
    drive_o = '0;
    unique case (phase_i)
      PH_HEAT:  drive_o.heat = heat_lvl;
      PH_FIELD: begin drive_o.heat = heat_lvl; drive_o.f1 = f1_lvl; drive_o.f2 = f2_lvl; end
      PH_COOL:  begin drive_o.f1 = f1_lvl; drive_o.f2 = f2_lvl; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/tas_cell_sequencer.sv
module tas_cell_sequencer
  import tas_seq_pkg::*;
#(
  parameter int ROWS      = 32,
  parameter int COLS      = 32,
  parameter int PULSE_CYC = 3,
  parameter int LSB_MV    = 20,
  parameter int UW_MIN_MV = 1000,
  parameter int UW_MAX_MV = 1800,
  localparam int ADDR_W   = $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        uw_heat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        heat_code_o,
  output logic [7:0]        fld1_code_o,
  output logic [7:0]        fld2_code_o,
  output logic              heat_en_o,
  output logic              field_en_o,
  output logic              cool_en_o,
  output logic              sample_o,
  output logic              done_o,
  output logic              busy_o
);
  phase_e            phase_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        uw_q;

  // Named internal events
  logic   phase_last;
  logic   accept;
  logic   read_op;
  logic   op_end;
  drive_t drive;

  assign accept  = (phase_q == PH_IDLE) && start_i;
  assign read_op = (op_q == OP_READ);
  assign op_end  = phase_last &&
                   ((phase_q == PH_COOL) || ((phase_q == PH_HEAT) && read_op));

  tas_phase_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (phase_q != PH_IDLE),
    .last_o (phase_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_CW0;
      addr_q  <= '0;
      uw_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_HEAT;
          op_q    <= op_e'(op_i);
          addr_q  <= addr_i;
          uw_q    <= uw_heat_i;
        end
        PH_HEAT:  if (phase_last) phase_q <= read_op ? PH_IDLE : PH_FIELD;
        PH_FIELD: if (phase_last) phase_q <= PH_COOL;
        PH_COOL:  if (phase_last) phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  tas_level_map #(
    .LSB_MV    (LSB_MV),
    .UW_MIN_MV (UW_MIN_MV),
    .UW_MAX_MV (UW_MAX_MV)
  ) u_map (
    .op_i      (op_q),
    .phase_i   (phase_q),
    .uw_heat_i (uw_q),
    .drive_o   (drive)
  );

  assign addr_o      = addr_q;
  assign heat_code_o = drive.heat;
  assign fld1_code_o = drive.f1;
  assign fld2_code_o = drive.f2;
  assign heat_en_o   = (phase_q == PH_HEAT);
  assign field_en_o  = (phase_q == PH_FIELD);
  assign cool_en_o   = (phase_q == PH_COOL);
  assign sample_o    = heat_en_o && read_op && phase_last;
  assign done_o      = op_end;
  assign busy_o      = (phase_q != PH_IDLE);
endmodule

// File: rtl/tas_cell_sequencer_chk.sv
module tas_cell_sequencer_chk #(
  parameter int PULSE_CYC = 3,
  parameter int ADDR_W    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_o,
  input logic [7:0]        heat_code_o,
  input logic [7:0]        fld1_code_o,
  input logic [7:0]        fld2_code_o,
  input logic              heat_en_o,
  input logic              field_en_o,
  input logic              cool_en_o,
  input logic              sample_o,
  input logic              done_o,
  input logic              busy_o
);
  logic [15:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= heat_en_o ? hcnt_q + 16'd1 : 16'd0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (heat_code_o == 8'd0 && fld1_code_o == 8'd0 && fld2_code_o == 8'd0 && !done_o));

  p_phase_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({heat_en_o, field_en_o, cool_en_o}) &&
    (busy_o == (heat_en_o || field_en_o || cool_en_o)));

  p_heat_to_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(heat_en_o) && busy_o) |-> field_en_o);

  p_field_to_cool_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field_en_o) |-> cool_en_o);

  p_heat_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(heat_en_o) |-> (hcnt_q == 16'(PULSE_CYC)));

  p_read_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (fld1_code_o == 8'd0 && fld2_code_o == 8'd0));

  p_sample_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (done_o && heat_en_o));

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(addr_o));

  p_cool_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cool_en_o) |-> (heat_code_o == 8'd0 && $stable(fld1_code_o) && $stable(fld2_code_o)));
endmodule

bind tas_cell_sequencer tas_cell_sequencer_chk #(
  .PULSE_CYC (PULSE_CYC),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_o      (addr_o),
  .heat_code_o (heat_code_o),
  .fld1_code_o (fld1_code_o),
  .fld2_code_o (fld2_code_o),
  .heat_en_o   (heat_en_o),
  .field_en_o  (field_en_o),
  .cool_en_o   (cool_en_o),
  .sample_o    (sample_o),
  .done_o      (done_o),
  .busy_o      (busy_o)
);

// File: tb/tas_cell_sequencer_bench.sv
module tas_cell_sequencer_bench;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [9:0] addr_i = '0;
  logic [7:0] uw_heat_i = '0;
  logic [9:0] addr_o;
  logic [7:0] heat_code_o, fld1_code_o, fld2_code_o;
  logic       heat_en_o, field_en_o, cool_en_o, sample_o, done_o, busy_o;

  always #10 clk = ~clk;

  tas_cell_sequencer #(.PULSE_CYC(P)) u_tas_cell_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
    .uw_heat_i(uw_heat_i), .addr_o(addr_o), .heat_code_o(heat_code_o),
    .fld1_code_o(fld1_code_o), .fld2_code_o(fld2_code_o), .heat_en_o(heat_en_o),
    .field_en_o(field_en_o), .cool_en_o(cool_en_o), .sample_o(sample_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit cmp_on = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mt = -1;
  int mop = 0;
  int maddr = 0;
  int muw = 0;

  function automatic int op_len(input int op);
    return (op == 3) ? P : 3 * P;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mt = -1; maddr = 0;
    end else if (mt >= 0) begin
      mt = mt + 1;
      if (mt == op_len(mop)) mt = -1;
    end else if (start_i) begin
      mt = 0; mop = int'(op_i); maddr = int'(addr_i); muw = int'(uw_heat_i);
    end
  end

  function automatic int uw_clamped(input int c);
    int v;
    v = c * 20;
    if (v < 1000) v = 1000;
    if (v > 1800) v = 1800;
    return v / 20;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      int ph, h, f1, f2;
      string creq;
      ph = (mt >= 0) ? mt / P : -1;
      h = 0; f1 = 0; f2 = 0;
      if (ph == 0 || ph == 1) begin
        case (mop)
          0: h = 2200 / 20;
          1: h = 3300 / 20;
          2: h = uw_clamped(muw);
          default: h = 300 / 20;
        endcase
      end
      if (ph == 1 || ph == 2) begin
        if (mop == 0 || mop == 2) f1 = 3300 / 20;
        if (mop == 1) f2 = 2200 / 20;
      end
      if (ph < 0) creq = "R12";
      else if (ph == 2) creq = "R11";
      else if (mop == 0) creq = "R4";
      else if (mop == 1) creq = "R5";
      else if (mop == 2) creq = "R6";
      else creq = "R7";
      chk("R3", "busy", int'(busy_o), int'(mt >= 0));
      chk("R3", "heat_en", int'(heat_en_o), int'(ph == 0));
      chk("R3", "field_en", int'(field_en_o), int'(ph == 1));
      chk("R3", "cool_en", int'(cool_en_o), int'(ph == 2));
      chk(creq, "heat_code", int'(heat_code_o), h);
      chk(creq, "fld1_code", int'(fld1_code_o), f1);
      chk(creq, "fld2_code", int'(fld2_code_o), f2);
      chk("R2", "addr", int'(addr_o), maddr);
      chk("R8", "sample", int'(sample_o), int'(mt >= 0 && mop == 3 && mt == P - 1));
      chk("R9", "done", int'(done_o), int'(mt >= 0 && mt == op_len(mop) - 1));
    end
  end

  task automatic run_op(input int op, input int addr, input int uw);
    @(negedge clk);
    start_i = 1'b1; op_i = 2'(op); addr_i = 10'(addr); uw_heat_i = 8'(uw);
    @(negedge clk);
    start_i = 1'b0;
    repeat (3 * P + 3) @(negedge clk);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "heat_code", int'(heat_code_o), 0);
    chk("R1", "fld_codes", int'(fld1_code_o) + int'(fld2_code_o), 0);
    chk("R1", "addr", int'(addr_o), 0);
    cmp_on = 1;

    run_op(0, 10, 0);     // write 0
    run_op(1, 1023, 0);   // write 1, last cell
    run_op(2, 33, 70);    // uncertain write, in range
    run_op(2, 34, 10);    // R6 clamp low
    run_op(2, 35, 200);   // R6 clamp high
    run_op(2, 36, 50);    // R6 lower bound exactly
    run_op(3, 512, 0);    // read
    run_op(3, 0, 0);

    // R10: start while busy and in the done cycle is ignored
    @(negedge clk);
    start_i = 1'b1; op_i = 2'd1; addr_i = 10'd100;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    start_i = 1'b1; op_i = 2'd3; addr_i = 10'd900;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3 * P - 4) @(negedge clk);
    chk("R9", "done cycle", int'(done_o), 1);
    start_i = 1'b1; op_i = 2'd3; addr_i = 10'd901;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10", "busy after done", int'(busy_o), 0);
    chk("R10", "addr kept", int'(addr_o), 100);
    repeat (3) @(negedge clk);
    chk("R10", "still idle", int'(busy_o), 0);

    // Start held high across several operations
    start_i = 1'b1; op_i = 2'd0; addr_i = 10'd5;
    repeat (25) @(negedge clk);
    op_i = 2'd3; addr_i = 10'd6;
    repeat (9) @(negedge clk);
    start_i = 1'b0;
    repeat (3 * P + 3) @(negedge clk);

    finished = 1;
    report();
  end
endmodule